// File: doc/BRIEF.md
# Paged Address Translator with Associative Frame Cache

This block turns a processor logical address into a physical address through a single-level page table. The logical address is a page number above a fixed-width offset. Pages and frames are both 2^OFS_W words, so the physical address is the frame number with the untouched offset appended. Before any lookup, the page number is compared against a length register. A page that is out of range is answered with a fault and causes no table read.

A small, fully associative cache holds recent page-to-frame pairs and answers a lookup in one cycle. On a miss the block reads one table entry from memory at (table base + page number) over a request/acknowledge port with variable latency. It stores the pair in the cache and then returns the translation. Only one translation is in flight at a time. A configuration port sets the base and length registers and can empty the cache. This port is gated by a privilege input. Saturating hit and miss counters can be read back on the same port to measure the hit ratio.

Top module: `paged_xlate`

## Requirements
- R1: The physical address is {frame, offset}. The offset is the low OFS_W bits of the logical address, the page number is the bits above it, and the frame is FN_W bits wide.
- R2: If the page number is not below the length register, the block answers with rsp_fault=1 and rsp_paddr=0 in the cycle after acceptance, and raises no mem_req for that request.
- R3: If the page number is held in a valid cache entry, the block answers with rsp_fault=0 in the cycle after acceptance, and raises no mem_req for that request.
- R4: On a miss, mem_req rises in the cycle after acceptance with mem_addr = (base + page) mod 2^MEM_AW, and mem_req and mem_addr stay stable until mem_ack. The response follows in the cycle after mem_ack, using the low FN_W bits of mem_rdata as the frame, and the page/frame pair is installed in the cache.
- R5: A fill takes the lowest-numbered invalid entry. When every entry is valid, fills replace entries in round-robin order, starting at entry 0 after reset.
- R6: A cycle with cfg_priv=1 and either cfg_flush=1 or a write to the base register invalidates every cache entry, so the next reference to any page misses.
- R7: A configuration write with cfg_we=1 and cfg_priv=1 updates the base register when cfg_sel=0 and the length register when cfg_sel=1. A write with cfg_priv=0 changes nothing.
- R8: req_ready is low from the acceptance of a miss until its response, and is high otherwise.
- R9: cfg_rdata shows, one cycle after cfg_sel is applied, the base (sel 0), the length (sel 1), the hit count (sel 2) or the miss count (sel 3). The hit and miss counters saturate at 2^CNT_W-1, and faults count as neither.
- R10: After reset, req_ready=1, rsp_valid=0, mem_req=0, the cache is empty, and base, length and both counters are 0, so every request faults.
- R11: With 4-word pages and a table mapping page 0 to frame 5, page 1 to frame 6 and page 3 to frame 2, logical addresses 0, 3, 4 and 13 translate to 20, 23, 24 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | PN_W+OFS_W | Logical address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | FN_W+OFS_W | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page number out of range |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | MEM_AW | Page-table entry address |
| mem_ack | input | 1 | Read data valid, one-cycle pulse |
| mem_rdata | input | FN_W | Frame number read from the table |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Privileged access qualifier |
| cfg_flush | input | 1 | Cache invalidate request |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_rdata | output | CFG_W | Registered read data |

## Verification
The assertions rely on the memory side to raise mem_ack only while mem_req is high, as a single-cycle pulse. They also rely on the configuration port not rewriting the base or flushing while a table read is outstanding. The bench's memory responder answers only an open request, after 0 to 3 idle cycles, and drops mem_ack in the next cycle. The bench issues configuration writes and flushes only when its reference model shows no request in flight. With these conditions met, no page can be installed twice, so at most one cache entry can match.

// File: rtl/xl_pkg.sv
package xl_pkg;
  typedef enum logic {ST_IDLE, ST_FETCH} xl_state_e;
  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_HITS = 2'd2;
  localparam logic [1:0] SEL_MISS = 2'd3;
endpackage

// File: rtl/xl_tlb.sv
module xl_tlb #(
  parameter int PN_W = 4,
  parameter int FN_W = 3,
  parameter int N    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PN_W-1:0] lk_page,
  output logic            lk_hit,
  output logic [FN_W-1:0] lk_frame,
  input  logic            fill_en,
  input  logic [PN_W-1:0] fill_page,
  input  logic [FN_W-1:0] fill_frame,
  input  logic            flush
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]    ent_v;
  logic [PN_W-1:0] ent_pg [N];
  logic [FN_W-1:0] ent_fr [N];
  logic [N-1:0]    match;
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] victim;
  logic             any_free;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = ent_v[i] && (ent_pg[i] == lk_page);
  end

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) lk_frame = lk_frame | ent_fr[i];
    end
  end
  assign lk_hit = |match;

  always_comb begin
    any_free = 1'b0;
    victim   = rr_ptr;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_v[i]) begin
        any_free = 1'b1;
        victim   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v  <= '0;
      rr_ptr <= '0;
    end else if (flush) begin
      ent_v <= '0;
    end else if (fill_en) begin
      ent_v[victim] <= 1'b1;
      if (!any_free) rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      ent_pg[victim] <= fill_page;
      ent_fr[victim] <= fill_frame;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ent_v == '0)); // R6
endmodule

// File: rtl/xl_cfg.sv
module xl_cfg #(
  parameter int MEM_AW = 8,
  parameter int LEN_W  = 5,
  parameter int CFG_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_priv,
  input  logic              cfg_flush,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              hit_pls,
  input  logic              miss_pls,
  output logic [MEM_AW-1:0] base_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              flush_o
);
  import xl_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] hit_cnt;
  logic [CNT_W-1:0] miss_cnt;
  logic             wr_ok;

  assign wr_ok   = cfg_we && cfg_priv;
  assign flush_o = cfg_priv && (cfg_flush || (cfg_we && cfg_sel == SEL_BASE));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      len_q     <= '0;
      hit_cnt   <= '0;
      miss_cnt  <= '0;
      cfg_rdata <= '0;
    end else begin
      if (wr_ok && cfg_sel == SEL_BASE) base_q <= cfg_wdata[MEM_AW-1:0];
      if (wr_ok && cfg_sel == SEL_LEN)  len_q  <= cfg_wdata[LEN_W-1:0];
      if (hit_pls && hit_cnt != CNT_MAX)   hit_cnt  <= hit_cnt + 1'b1;
      if (miss_pls && miss_cnt != CNT_MAX) miss_cnt <= miss_cnt + 1'b1;
      case (cfg_sel)
        SEL_BASE: cfg_rdata <= CFG_W'(base_q);
        SEL_LEN:  cfg_rdata <= CFG_W'(len_q);
        SEL_HITS: cfg_rdata <= CFG_W'(hit_cnt);
        default:  cfg_rdata <= CFG_W'(miss_cnt);
      endcase
    end
  end

  AST_PRIV_ONLY: assert property (@(posedge clk) disable iff (rst)
    !cfg_priv |=> ($stable(base_q) && $stable(len_q))); // R7
  AST_HIT_SAT: assert property (@(posedge clk) disable iff (rst)
    (hit_cnt == CNT_MAX) |=> (hit_cnt == CNT_MAX)); // R9
  AST_MISS_SAT: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt == CNT_MAX) |=> (miss_cnt == CNT_MAX)); // R9
endmodule

// File: rtl/paged_xlate.sv
module paged_xlate #(
  parameter int OFS_W  = 2,
  parameter int PN_W   = 4,
  parameter int FN_W   = 3,
  parameter int TLB_N  = 4,
  parameter int MEM_AW = 8,
  parameter int CFG_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [PN_W+OFS_W-1:0] req_laddr,
  output logic                  rsp_valid,
  output logic [FN_W+OFS_W-1:0] rsp_paddr,
  output logic                  rsp_fault,
  output logic                  mem_req,
  output logic [MEM_AW-1:0]     mem_addr,
  input  logic                  mem_ack,
  input  logic [FN_W-1:0]       mem_rdata,
  input  logic                  cfg_we,
  input  logic                  cfg_priv,
  input  logic                  cfg_flush,
  input  logic [1:0]            cfg_sel,
  input  logic [CFG_W-1:0]      cfg_wdata,
  output logic [CFG_W-1:0]      cfg_rdata
);
  import xl_pkg::*;

  localparam int LA_W  = PN_W + OFS_W;
  localparam int LEN_W = PN_W + 1;

  xl_state_e        state;
  logic [PN_W-1:0]  page_in;
  logic [OFS_W-1:0] ofs_in;
  logic [PN_W-1:0]  hold_page;
  logic [OFS_W-1:0] hold_ofs;
  logic [MEM_AW-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic             flush;
  logic             accept;
  logic             in_range;
  logic             tlb_hit;
  logic [FN_W-1:0]  tlb_frame;
  logic             fill_en;
  logic             hit_pls;
  logic             miss_pls;

  assign page_in   = req_laddr[LA_W-1:OFS_W];
  assign ofs_in    = req_laddr[OFS_W-1:0];
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_range  = ({1'b0, page_in} < len_q);
  assign hit_pls   = accept && in_range && tlb_hit;
  assign miss_pls  = accept && in_range && !tlb_hit;
  assign fill_en   = (state == ST_FETCH) && mem_ack;

  xl_tlb #(.PN_W(PN_W), .FN_W(FN_W), .N(TLB_N)) u_tlb (
    .clk(clk), .rst(rst),
    .lk_page(page_in), .lk_hit(tlb_hit), .lk_frame(tlb_frame),
    .fill_en(fill_en), .fill_page(hold_page), .fill_frame(mem_rdata),
    .flush(flush)
  );

  xl_cfg #(.MEM_AW(MEM_AW), .LEN_W(LEN_W), .CFG_W(CFG_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_flush(cfg_flush),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .hit_pls(hit_pls), .miss_pls(miss_pls),
    .base_q(base_q), .len_q(len_q), .flush_o(flush)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      hold_page <= '0;
      hold_ofs  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!in_range) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_paddr <= '0;
            end else if (tlb_hit) begin
              rsp_valid <= 1'b1;
              rsp_paddr <= {tlb_frame, ofs_in};
            end else begin
              state     <= ST_FETCH;
              mem_req   <= 1'b1;
              mem_addr  <= base_q + MEM_AW'(page_in);
              hold_page <= page_in;
              hold_ofs  <= ofs_in;
            end
          end
        end
        default: begin
          if (mem_ack) begin
            state     <= ST_IDLE;
            mem_req   <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_paddr <= {mem_rdata, hold_ofs};
          end
        end
      endcase
    end
  end

  AST_FAULT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_range) |=> (rsp_valid && rsp_fault && !mem_req)); // R2
  AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    hit_pls |=> (rsp_valid && !rsp_fault && !mem_req)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready); // R8
endmodule

// File: tb/paged_xlate_test.sv
module paged_xlate_test;
  localparam int OFS_W = 2, PN_W = 4, FN_W = 3, TLB_N = 4, MEM_AW = 8, CFG_W = 16, CNT_W = 4;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [5:0] req_laddr = '0;
  logic rsp_valid, rsp_fault, mem_req;
  logic [4:0] rsp_paddr;
  logic [7:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [2:0] mem_rdata = '0;
  logic cfg_we = 1'b0, cfg_priv = 1'b0, cfg_flush = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;

  always #4 clk = ~clk;

  paged_xlate #(.OFS_W(OFS_W), .PN_W(PN_W), .FN_W(FN_W), .TLB_N(TLB_N),
                .MEM_AW(MEM_AW), .CFG_W(CFG_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cfg_we(cfg_we),
    .cfg_priv(cfg_priv), .cfg_flush(cfg_flush), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  int n_chk = 0, n_fail = 0, cycles = 0, fetches = 0;
  logic [2:0] tbl [256];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_busy = 0, m_live = 0;
  int m_base = 0, m_len = 0, m_hits = 0, m_miss = 0, m_rr = 0, m_pg = 0, m_of = 0;
  bit mv [4];
  int mp [4], mf [4];
  bit e_rv = 0, e_flt = 0, e_mreq = 0;
  int e_pa = 0, e_maddr = 0, e_rd = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_base = 0; m_len = 0; m_hits = 0; m_miss = 0; m_rr = 0;
      for (int i = 0; i < 4; i++) mv[i] = 0;
      e_rv = 0; e_flt = 0; e_mreq = 0; e_pa = 0; e_maddr = 0; e_rd = 0;
      m_live = 1;
    end else begin
      int pg, of, hx, vic;
      case (cfg_sel)
        2'd0: e_rd = m_base;
        2'd1: e_rd = m_len;
        2'd2: e_rd = m_hits;
        default: e_rd = m_miss;
      endcase
      e_rv = 0; e_flt = 0;
      if (req_valid && !m_busy) begin
        pg = int'(req_laddr) / 4; of = int'(req_laddr) % 4;
        if (pg >= m_len) begin
          e_rv = 1; e_flt = 1; e_pa = 0;
        end else begin
          hx = -1;
          for (int i = 0; i < 4; i++) if (mv[i] && mp[i] == pg) hx = i;
          if (hx >= 0) begin
            e_rv = 1; e_pa = mf[hx] * 4 + of;
            if (m_hits < CMAX) m_hits++;
          end else begin
            m_busy = 1; e_mreq = 1; e_maddr = (m_base + pg) % 256;
            m_pg = pg; m_of = of;
            if (m_miss < CMAX) m_miss++;
          end
        end
      end else if (m_busy && mem_ack) begin
        vic = -1;
        for (int i = 3; i >= 0; i--) if (!mv[i]) vic = i;
        if (vic < 0) begin vic = m_rr; m_rr = (m_rr + 1) % 4; end
        mv[vic] = 1; mp[vic] = m_pg; mf[vic] = int'(mem_rdata);
        e_rv = 1; e_pa = int'(mem_rdata) * 4 + m_of; e_mreq = 0; m_busy = 0;
      end
      if (cfg_we && cfg_priv && cfg_sel == 2'd0) m_base = int'(cfg_wdata) % 256;
      if (cfg_we && cfg_priv && cfg_sel == 2'd1) m_len = int'(cfg_wdata) % 32;
      if (cfg_priv && (cfg_flush || (cfg_we && cfg_sel == 2'd0)))
        for (int i = 0; i < 4; i++) mv[i] = 0;
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (m_live && !rst) begin
      chk(req_ready == !m_busy, "R8 req_ready", int'(req_ready), int'(!m_busy));
      chk(rsp_valid == e_rv, "R3 rsp_valid", int'(rsp_valid), int'(e_rv));
      if (e_rv) begin
        chk(rsp_fault == e_flt, "R2 rsp_fault", int'(rsp_fault), int'(e_flt));
        chk(int'(rsp_paddr) == e_pa, "R1 rsp_paddr", int'(rsp_paddr), e_pa);
      end
      chk(mem_req == e_mreq, "R4 mem_req", int'(mem_req), int'(e_mreq));
      if (e_mreq) chk(int'(mem_addr) == e_maddr, "R4 mem_addr", int'(mem_addr), e_maddr);
      chk(int'(cfg_rdata) == e_rd, "R9 cfg_rdata", int'(cfg_rdata), e_rd);
    end
  end

  // page-table memory responder with variable latency
  int wait_cnt = 0, lat_seed = 0;
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack = 1'b1; mem_rdata = tbl[mem_addr]; fetches++;
        lat_seed++; wait_cnt = lat_seed % 4;
      end else wait_cnt--;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic cfg_wr(input logic [1:0] s, input int d, input bit pv);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = 16'(d); cfg_priv = pv;
    @(negedge clk); cfg_we = 1'b0; cfg_priv = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); cfg_flush = 1'b1; cfg_priv = 1'b1;
    @(negedge clk); cfg_flush = 1'b0; cfg_priv = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] s, output int v);
    @(negedge clk); cfg_sel = s;
    @(negedge clk); v = int'(cfg_rdata);
  endtask

  task automatic xlate(input int a, output int pa, output bit f);
    @(negedge clk); req_valid = 1'b1; req_laddr = 6'(a);
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    pa = int'(rsp_paddr); f = rsp_fault;
  endtask

  initial begin
    int pa, f0, v, lf;
    bit f;
    for (int i = 0; i < 256; i++) tbl[i] = 3'((i * 3 + 1) % 8);
    tbl[8'h40] = 3'd5; tbl[8'h41] = 3'd6; tbl[8'h43] = 3'd2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R10 rsp_valid after reset", int'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R10 mem_req after reset", int'(mem_req), 0);
    xlate(0, pa, f);
    chk(f == 1'b1, "R10 fault with zero length", int'(f), 1);

    cfg_wr(2'd0, 8'h40, 1'b1);
    cfg_wr(2'd1, 4, 1'b1);
    xlate(0, pa, f);  chk(pa == 20, "R11 addr 0", pa, 20);
    xlate(3, pa, f);  chk(pa == 23, "R11 addr 3", pa, 23);
    xlate(4, pa, f);  chk(pa == 24, "R11 addr 4", pa, 24);
    xlate(13, pa, f); chk(pa == 9, "R11 addr 13", pa, 9);
    chk(fetches == 3, "R3 hit made no table read", fetches, 3);

    f0 = fetches;
    xlate(16, pa, f);
    chk(f == 1'b1 && pa == 0, "R2 page 4 beyond length", pa, 0);
    chk(fetches == f0, "R2 no table read on fault", fetches, f0);

    cfg_wr(2'd1, 16, 1'b0);
    cfg_rd(2'd1, v);
    chk(v == 4, "R7 unprivileged length write ignored", v, 4);
    xlate(16, pa, f);
    chk(f == 1'b1, "R7 still faults", int'(f), 1);
    cfg_wr(2'd1, 16, 1'b1);
    cfg_rd(2'd1, v);
    chk(v == 16, "R7 privileged length write", v, 16);

    // entries: 0=p0, 1=p1, 2=p3; fill p5 -> entry 3, p6 -> entry 0 (evicts p0)
    xlate(20, pa, f); xlate(24, pa, f);
    f0 = fetches;
    xlate(0, pa, f);
    chk(fetches == f0 + 1, "R5 round-robin evicted page 0", fetches, f0 + 1);
    f0 = fetches;
    xlate(12, pa, f);
    chk(fetches == f0, "R5 page 3 retained", fetches, f0);

    do_flush();
    f0 = fetches;
    xlate(12, pa, f);
    chk(fetches == f0 + 1, "R6 miss after flush", fetches, f0 + 1);
    chk(pa == 8, "R4 frame from table", pa, 8);

    for (int k = 0; k < 20; k++) xlate(12, pa, f);
    cfg_rd(2'd2, v);
    chk(v == CMAX, "R9 hit counter saturates", v, CMAX);

    lf = 32'h1ace;
    for (int k = 0; k < 400; k++) begin
      lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
      if ((lf >> 8) % 23 == 0) do_flush();
      else if ((lf >> 8) % 29 == 0) cfg_wr(2'd0, (lf >> 12) % 256, 1'b1);
      else if ((lf >> 8) % 31 == 0) cfg_wr(2'd1, (lf >> 12) % 17, (lf >> 20) % 2 == 1);
      xlate((lf >> 4) % 64, pa, f);
      cfg_sel = 2'((lf >> 16) % 4);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule